// File: doc/BRIEF.md
# Integer ALU with Status Flags

A purely combinational integer arithmetic and logic unit for the execute stage of a general-purpose processor datapath. It takes a destination operand, a source operand, an operation code, an operand-size code and the current status flags. In the same cycle it returns a result, the updated six-bit status word and a result write-enable. The operand size is 8, 16 or 32 bits. Every flag is formed at that width, and result bits above the width are driven to zero.

The operations are addition, subtraction (destination minus source), comparison, increment, decrement, two's-complement negation, the bitwise operations AND, OR, XOR and NOT, and arithmetic shifts left and right. One carry-chain adder serves signed and unsigned operands. Flags that an operation leaves alone are copied from the incoming status word, so the caller can write the output back to its flag register every cycle without decoding the operation itself.

Top module: `int_alu`

## Requirements
- R1: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the selected width have no effect. Result bits above it are 0. The status word bit positions are carry 0, parity 1, auxiliary 2, zero 3, sign 4 and overflow 5.
- R2: Operation 0 (add) returns dest+src and operation 1 (subtract) returns dest-src, both modulo 2^width. Carry is the unsigned carry-out for add and the unsigned borrow for subtract. Overflow is 1 exactly when the signed result falls outside the signed range of the width.
- R3: Operation 2 (compare) produces the same result and flags as subtract, with write-enable 0. Every defined operation other than compare drives write-enable 1.
- R4: For every operation that updates flags, zero is 1 only when the result at the width is 0. Sign equals the result's top bit at the width. Parity is 1 when the result's low byte holds an even number of ones.
- R5: For add, subtract, compare, increment, decrement and negate, auxiliary is 1 when the low-nibble addition carries out of bit 3, or when the low-nibble subtraction borrows into it.
- R6: Operation 3 (increment) adds one and operation 4 (decrement) subtracts one. Both update overflow, auxiliary, zero, sign and parity, and both copy the incoming carry.
- R7: Operation 5 (negate) returns 0-dest. Carry is 1 exactly when the operand at the width is nonzero.
- R8: Operations 6, 7 and 8 (AND, OR, XOR) clear carry, overflow and auxiliary. Operation 9 (NOT) returns the bitwise inverse of dest and copies all six flags unchanged.
- R9: Operation 10 (shift left) shifts dest left by src[4:0] and fills with zeros. Carry is the last bit shifted out of the width, or 0 when the count exceeds the width. Overflow is the result's top bit XOR carry. Auxiliary is cleared.
- R10: Operation 11 (arithmetic shift right) shifts dest right by src[4:0] and fills with copies of the sign bit. Carry is the last bit shifted out, or the sign bit when the count exceeds the width. Overflow and auxiliary are cleared.
- R11: For either shift with a count of zero, the result equals dest at the width and all six flags are copied unchanged.
- R12: Operation codes 12 to 15 give result 0 and write-enable 0, and copy all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand-size code |
| dst_i | input | 32 | Destination (first) operand |
| src_i | input | 32 | Source operand or shift count |
| flags_i | input | 6 | Incoming status flags |
| result_o | output | 32 | Result, zero above the selected width |
| flags_o | output | 6 | Updated status flags |
| wr_en_o | output | 1 | Result write-enable |

## Verification
The carry out of the top bit and the nibble carry out of bit 3 come from the same adder pass. Signed overflow and unsigned carry can also rise together, for example 0x80+0x80 at 8 bits. The sweeps drive every 8-bit destination against sources at 0x0F, 0x10, 0x7F, 0x80, 0xFE and 0xFF, so that both boundaries are crossed at once. They also pair extreme values at 16 and 32 bits. Each vector is judged by comparing all six flags, the result and the write-enable in one compare against a model built from integer arithmetic on signed and unsigned interpretations, not from bit-level carries.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W  = 32;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int WIDE_W  = 2 * DATA_W;
  localparam int FLAG_N  = 6;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_CMP = 4'd2;
  localparam logic [3:0] OP_INC = 4'd3;
  localparam logic [3:0] OP_DEC = 4'd4;
  localparam logic [3:0] OP_NEG = 4'd5;
  localparam logic [3:0] OP_AND = 4'd6;
  localparam logic [3:0] OP_OR  = 4'd7;
  localparam logic [3:0] OP_XOR = 4'd8;
  localparam logic [3:0] OP_NOT = 4'd9;
  localparam logic [3:0] OP_SHL = 4'd10;
  localparam logic [3:0] OP_SAR = 4'd11;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // Field order gives: carry bit 0 ... overflow bit 5
  typedef struct packed {
    logic o;
    logic s;
    logic z;
    logic a;
    logic p;
    logic c;
  } flags_t;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return {{(DATA_W-8){1'b0}}, 8'hFF};
      SZ_HALF: return {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  function automatic logic top_bit(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return v[7];
      SZ_HALF: return v[15];
      default: return v[DATA_W-1];
    endcase
  endfunction

  // Bit just above the selected width of a wider vector
  function automatic logic carry_bit(input logic [DATA_W:0] v, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return v[8];
      SZ_HALF: return v[16];
      default: return v[DATA_W];
    endcase
  endfunction

  function automatic logic [WIDE_W-1:0] sign_ext(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return {{(WIDE_W-8){v[7]}}, v[7:0]};
      SZ_HALF: return {{(WIDE_W-16){v[15]}}, v[15:0]};
      default: return {{(WIDE_W-DATA_W){v[DATA_W-1]}}, v};
    endcase
  endfunction

  function automatic logic even_ones(input logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
(
  input  logic [3:0]        op_i,
  input  logic [1:0]        sz_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              af_o
);
  logic [DATA_W-1:0] mask, lhs, rhs, rhs_eff;
  logic              sub_mode;
  logic [DATA_W:0]   sum_w;
  logic              cout;

  always_comb begin
    mask     = size_mask(sz_i);
    lhs      = a_i & mask;
    rhs      = b_i & mask;
    sub_mode = 1'b0;
    case (op_i)
      OP_SUB, OP_CMP: sub_mode = 1'b1;
      OP_INC: rhs = {{(DATA_W-1){1'b0}}, 1'b1};
      OP_DEC: begin
        rhs      = {{(DATA_W-1){1'b0}}, 1'b1};
        sub_mode = 1'b1;
      end
      OP_NEG: begin
        lhs      = '0;
        rhs      = a_i & mask;
        sub_mode = 1'b1;
      end
      default: ;
    endcase
    rhs_eff = sub_mode ? (~rhs & mask) : rhs;
  end

  // One adder for all: subtract is lhs + ~rhs + 1
  assign sum_w = {1'b0, lhs} + {1'b0, rhs_eff} + {{DATA_W{1'b0}}, sub_mode};
  assign cout  = carry_bit(sum_w, sz_i);
  assign res_o = sum_w[DATA_W-1:0] & mask;
  assign cf_o  = sub_mode ? ~cout : cout;
  assign af_o  = lhs[4] ^ rhs[4] ^ res_o[4];
  assign of_o  = (top_bit(lhs, sz_i) == top_bit(rhs_eff, sz_i)) &&
                 (top_bit(res_o, sz_i) != top_bit(lhs, sz_i));
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
(
  input  logic [3:0]        op_i,
  input  logic [1:0]        sz_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] raw;

  always_comb begin
    case (op_i)
      OP_AND:  raw = a_i & b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      default: raw = ~a_i;
    endcase
  end

  assign res_o = raw & size_mask(sz_i);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
(
  input  logic               right_i,
  input  logic [1:0]         sz_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [SHAMT_W-1:0] cnt_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               cf_o,
  output logic               of_o,
  output logic               idle_o
);
  logic [DATA_W-1:0]        mask;
  logic [WIDE_W-1:0]        wide_l;
  logic signed [WIDE_W-1:0] sx;
  logic signed [WIDE_W-1:0] pre;
  logic [SHAMT_W-1:0]       cnt_m1;
  logic [DATA_W-1:0]        l_res, r_res;
  logic                     l_cf, r_cf;
  logic                     unused_hi;

  assign mask   = size_mask(sz_i);
  assign idle_o = (cnt_i == '0);
  assign cnt_m1 = cnt_i - 1'b1;

  // Left: the last bit out lands at position width of the wide vector
  assign wide_l = {{DATA_W{1'b0}}, a_i & mask} << cnt_i;
  assign l_res  = wide_l[DATA_W-1:0] & mask;
  assign l_cf   = carry_bit(wide_l[DATA_W:0], sz_i);

  // Right: stop one place short so bit 0 is the last bit out
  assign sx     = signed'(sign_ext(a_i, sz_i));
  assign pre    = sx >>> cnt_m1;
  assign r_cf   = pre[0];
  assign r_res  = pre[DATA_W:1] & mask;

  assign unused_hi = ^{wide_l[WIDE_W-1:DATA_W+1], pre[WIDE_W-1:DATA_W+1]};

  assign res_o = right_i ? r_res : l_res;
  assign cf_o  = right_i ? r_cf : l_cf;
  assign of_o  = right_i ? 1'b0 : (top_bit(l_res, sz_i) ^ l_cf);
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
(
  input  logic [3:0]  op_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] dst_i,
  input  logic [31:0] src_i,
  input  logic [5:0]  flags_i,
  output logic [31:0] result_o,
  output logic [5:0]  flags_o,
  output logic        wr_en_o
);
  logic [DATA_W-1:0] ar_res, lg_res, sh_res;
  logic              ar_cf, ar_of, ar_af;
  logic              sh_cf, sh_of;
  logic              shift_idle;
  logic              zsp_update;
  logic [DATA_W-1:0] res;
  flags_t            fl;
  logic              wr;

  alu_arith u_arith (
    .op_i (op_i), .sz_i (size_i), .a_i (dst_i), .b_i (src_i),
    .res_o (ar_res), .cf_o (ar_cf), .of_o (ar_of), .af_o (ar_af)
  );

  alu_logic u_logic (
    .op_i (op_i), .sz_i (size_i), .a_i (dst_i), .b_i (src_i), .res_o (lg_res)
  );

  alu_shifter u_shift (
    .right_i (op_i == OP_SAR), .sz_i (size_i), .a_i (dst_i),
    .cnt_i (src_i[SHAMT_W-1:0]),
    .res_o (sh_res), .cf_o (sh_cf), .of_o (sh_of), .idle_o (shift_idle)
  );

  always_comb begin
    fl         = flags_t'(flags_i);
    res        = '0;
    wr         = 1'b1;
    zsp_update = 1'b1;
    case (op_i)
      OP_ADD, OP_SUB, OP_CMP, OP_NEG: begin
        res  = ar_res;
        fl.c = ar_cf;
        fl.o = ar_of;
        fl.a = ar_af;
      end
      OP_INC, OP_DEC: begin
        res  = ar_res;
        fl.o = ar_of;
        fl.a = ar_af;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res  = lg_res;
        fl.c = 1'b0;
        fl.o = 1'b0;
        fl.a = 1'b0;
      end
      OP_NOT: begin
        res        = lg_res;
        zsp_update = 1'b0;
      end
      OP_SHL, OP_SAR: begin
        if (shift_idle) begin
          res        = dst_i & size_mask(size_i);
          zsp_update = 1'b0;
        end else begin
          res  = sh_res;
          fl.c = sh_cf;
          fl.o = sh_of;
          fl.a = 1'b0;
        end
      end
      default: begin
        wr         = 1'b0;
        zsp_update = 1'b0;
      end
    endcase
    if (op_i == OP_CMP) wr = 1'b0;
    if (zsp_update) begin
      fl.z = (res == '0);
      fl.s = top_bit(res, size_i);
      fl.p = even_ones(res[7:0]);
    end
  end

  assign result_o = res;
  assign flags_o  = fl;
  assign wr_en_o  = wr;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk (
  input logic [3:0]  op_i,
  input logic [1:0]  size_i,
  input logic [31:0] dst_i,
  input logic [31:0] src_i,
  input logic [5:0]  flags_i,
  input logic [31:0] result_o,
  input logic [5:0]  flags_o,
  input logic        wr_en_o,
  input logic        zsp_update
);
  logic [31:0] wmask;

  always_comb begin
    case (size_i)
      2'd0:    wmask = 32'h0000_00FF;
      2'd1:    wmask = 32'h0000_FFFF;
      default: wmask = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    AST_UPPER_CLEAR: assert ((result_o & ~wmask) == 32'h0) else $error("upper result bits set"); // R1
    if (op_i == 4'd2) begin
      AST_CMP_NO_WRITE: assert (!wr_en_o) else $error("compare wrote result"); // R3
    end
    if (zsp_update) begin
      AST_ZERO_FLAG: assert (flags_o[3] == (result_o == 32'h0)) else $error("zero flag mismatch"); // R4
    end
    if (op_i == 4'd3 || op_i == 4'd4) begin
      AST_KEEP_CARRY: assert (flags_o[0] == flags_i[0]) else $error("carry not kept"); // R6
    end
    if (op_i == 4'd5) begin
      AST_NEG_CARRY: assert (flags_o[0] == ((dst_i & wmask) != 32'h0)) else $error("negate carry"); // R7
    end
    if (op_i >= 4'd6 && op_i <= 4'd8) begin
      AST_LOGIC_CLEAR: assert (flags_o[0] == 1'b0 && flags_o[5] == 1'b0 && flags_o[2] == 1'b0) else $error("logic flags"); // R8
    end
    if (op_i == 4'd9) begin
      AST_NOT_FLAGS: assert (flags_o == flags_i) else $error("not touched flags"); // R8
    end
    if ((op_i == 4'd10 || op_i == 4'd11) && src_i[4:0] == 5'd0) begin
      AST_SHIFT_IDLE: assert (flags_o == flags_i && result_o == (dst_i & wmask)) else $error("zero shift"); // R11
    end
    if (op_i >= 4'd12) begin
      AST_UNDEF_OP: assert (!wr_en_o && flags_o == flags_i && result_o == 32'h0) else $error("undefined op"); // R12
    end
  end
endmodule

bind int_alu int_alu_chk u_int_alu_chk (
  .op_i (op_i), .size_i (size_i), .dst_i (dst_i), .src_i (src_i),
  .flags_i (flags_i), .result_o (result_o), .flags_o (flags_o),
  .wr_en_o (wr_en_o), .zsp_update (zsp_update)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [1:0]  sz = 2'd0;
  logic [31:0] a = 32'd0;
  logic [31:0] b = 32'd0;
  logic [5:0]  fin = 6'd0;
  logic [31:0] result;
  logic [5:0]  flags;
  logic        wr_en;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  int_alu u_int_alu (
    .op_i (op), .size_i (sz), .dst_i (a), .src_i (b), .flags_i (fin),
    .result_o (result), .flags_o (flags), .wr_en_o (wr_en)
  );

  logic [7:0]  small_b [12] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80,
                                8'h81, 8'hFE, 8'hFF, 8'h55, 8'hAA, 8'h33};
  logic [31:0] big_v [12] = '{32'h0, 32'h1, 32'hF, 32'h7F, 32'h7FFF, 32'h8000,
                              32'hFFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h1234_5678, 32'h0001_0011};

  function automatic longint sgn(input longint unsigned v, input int w);
    if (((v >> (w - 1)) & 64'd1) != 0) return longint'(v) - longint'(64'd1 << w);
    return longint'(v);
  endfunction

  function automatic bit out_of_range(input longint v, input int w);
    longint hi, lo;
    hi = longint'(64'd1 << (w - 1)) - 1;
    lo = -longint'(64'd1 << (w - 1));
    return (v > hi) || (v < lo);
  endfunction

  // Expected {wr_en, flags[5:0], result[31:0]} built from integer arithmetic
  function automatic logic [38:0] model(input logic [3:0] o, input logic [1:0] s,
                                        input logic [31:0] x, input logic [31:0] y,
                                        input logic [5:0] f);
    int w;
    longint unsigned m, ux, uy, r, full;
    longint sx, sy, t;
    bit c, v, ax, wr, upd;
    int cnt, ones;
    logic [5:0] fo;
    w   = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m   = (64'd1 << w) - 1;
    ux  = longint'(x) & m;
    uy  = longint'(y) & m;
    sx  = sgn(ux, w);
    sy  = sgn(uy, w);
    c   = f[0]; v = f[5]; ax = f[2];
    wr  = 1'b1; upd = 1'b1; r = 0;
    cnt = int'(y[4:0]);
    case (o)
      4'd0: begin r = (ux + uy) & m; c = (ux + uy) > m; v = out_of_range(sx + sy, w);
                  ax = ((ux % 16) + (uy % 16)) > 15; end
      4'd1, 4'd2: begin r = (ux - uy) & m; c = ux < uy; v = out_of_range(sx - sy, w);
                  ax = (ux % 16) < (uy % 16); if (o == 4'd2) wr = 1'b0; end
      4'd3: begin r = (ux + 1) & m; v = out_of_range(sx + 1, w); ax = (ux % 16) == 15; end
      4'd4: begin r = (ux - 1) & m; v = out_of_range(sx - 1, w); ax = (ux % 16) == 0; end
      4'd5: begin r = (0 - ux) & m; c = ux != 0; v = out_of_range(-sx, w); ax = (ux % 16) != 0; end
      4'd6: begin r = ux & uy; c = 0; v = 0; ax = 0; end
      4'd7: begin r = ux | uy; c = 0; v = 0; ax = 0; end
      4'd8: begin r = ux ^ uy; c = 0; v = 0; ax = 0; end
      4'd9: begin r = (~ux) & m; upd = 1'b0; end
      4'd10: begin
        if (cnt == 0) begin r = ux; upd = 1'b0; end
        else begin full = ux << cnt; r = full & m; c = ((full >> w) & 1) != 0;
                   v = (((r >> (w - 1)) & 1) != 0) ^ c; ax = 0; end
      end
      4'd11: begin
        if (cnt == 0) begin r = ux; upd = 1'b0; end
        else begin t = sx >>> (cnt - 1); c = (t & 1) != 0;
                   r = longint'(t >>> 1) & m; v = 0; ax = 0; end
      end
      default: begin r = 0; wr = 1'b0; upd = 1'b0; end
    endcase
    fo = f;
    fo[0] = c; fo[5] = v; fo[2] = ax;
    if (upd) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'((r >> i) & 1);
      fo[3] = (r == 0);
      fo[4] = ((r >> (w - 1)) & 1) != 0;
      fo[1] = (ones % 2) == 0;
    end
    return {wr, fo, r[31:0]};
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic [31:0] y);
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7, 4'd8, 4'd9: return "R8";
      4'd10: return (y[4:0] == 5'd0) ? "R11" : "R9";
      4'd11: return (y[4:0] == 5'd0) ? "R11" : "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic run(input logic [3:0] o, input logic [1:0] s, input logic [31:0] x,
                     input logic [31:0] y, input logic [5:0] f, input string tg);
    logic [38:0] exp, got;
    @(negedge clk);
    op = o; sz = s; a = x; b = y; fin = f;
    #1;
    exp = model(o, s, x, y, f);
    got = {wr_en, flags, result};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d sz=%0d a=%h b=%h fin=%b actual=%h expected=%h",
               tg, o, s, x, y, f, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state with all-zero inputs: add of zeros
    run(4'd0, 2'd0, 32'h0, 32'h0, 6'h00, "R4");
    // Directed flag corners
    run(4'd0, 2'd0, 32'h0F, 32'h01, 6'h00, "R5");
    run(4'd0, 2'd0, 32'hFF, 32'h01, 6'h00, "R4");
    run(4'd1, 2'd0, 32'h10, 32'h01, 6'h00, "R5");
    run(4'd0, 2'd0, 32'h80, 32'h80, 6'h00, "R2");
    // Upper operand bits ignored, reserved size code
    run(4'd0, 2'd0, 32'hABCD_12F0, 32'h5555_0010, 6'h00, "R1");
    run(4'd11, 2'd1, 32'hFFFF_8001, 32'hFFFF_FFE1, 6'h3F, "R1");
    run(4'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, 6'h00, "R1");
    run(4'd5, 2'd3, 32'h8000_0000, 32'h0, 6'h00, "R1");

    // 8-bit arithmetic and logic sweeps
    for (int o = 0; o <= 8; o++) begin
      if (o >= 3 && o <= 5) continue;
      for (int x = 0; x < 256; x++)
        for (int k = 0; k < 12; k++)
          run(4'(o), 2'd0, 32'(x), {24'h0, small_b[k]}, 6'h15, tag_of(4'(o), 32'(small_b[k])));
    end
    for (int o = 3; o <= 9; o++) begin
      if (o >= 6 && o <= 8) continue;
      for (int x = 0; x < 256; x++) begin
        run(4'(o), 2'd0, 32'(x), 32'h0, 6'h00, tag_of(4'(o), 32'h0));
        run(4'(o), 2'd0, 32'(x), 32'h0, 6'h3F, tag_of(4'(o), 32'h0));
      end
    end
    // 8-bit shift sweep, all counts
    for (int o = 10; o <= 11; o++)
      for (int x = 0; x < 256; x++)
        for (int n = 0; n < 32; n++)
          run(4'(o), 2'd0, 32'(x), 32'(n), 6'h2A, tag_of(4'(o), 32'(n)));
    // 16 and 32-bit extreme pairs, all defined operations
    for (int s = 1; s <= 2; s++)
      for (int o = 0; o < 12; o++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++)
            run(4'(o), 2'(s), big_v[i], big_v[j], 6'h2D, tag_of(4'(o), big_v[j]));
    // Undefined operation codes
    for (int o = 12; o < 16; o++) begin
      run(4'(o), 2'd2, 32'hDEAD_BEEF, 32'h1, 6'h2D, "R12");
      run(4'(o), 2'd0, 32'h0, 32'h0, 6'h12, "R12");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule